// File: doc/BRIEF.md
# Selectable Odd/Even Output Clock Divider

This block takes a fast source clock, standing in for an oscillator core, and divides it by three, four, five or six. A two-bit select, normally held in a configuration register, picks the ratio. The result is a square wave whose high time is exactly half its period, odd ratios included. The same divided clock goes to a set of parallel outputs that stay in phase. Each output has its own enable flag, which models a pin that drives or floats.

A new select value is adopted only when the current output period ends, so switching ratios never leaves a shortened pulse. An active-high synchronous reset pulls every clock output low. After the reset is released, the first output rising edge comes on the next source rising edge.

Top module: `clkdiv_sel`

## Requirements
- R1: The select picks the ratio N as 3 + sel, so 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 6. Each output period lasts exactly 2N source half-periods.
- R2: In every period the output is high for exactly N source half-periods, odd N included.
- R3: While reset is held, every clock output is low from the first source rising edge of the reset onward.
- R4: On the first source rising edge after reset is released, every clock output goes high.
- R5: A change of select during a period does not alter that period. The new ratio starts with the next period.
- R6: All clock outputs carry the same value at all times.
- R7: Each enable flag repeats its enable input one source cycle later. Reset sets every enable flag to 1 (driven).
- R8: A cleared enable flag has no effect on the clock value the output carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | SEL_W | Ratio select, ratio = RATIO_MIN + sel |
| oe_in | input | NUM_OUT | Per-output enable request |
| clk_out | output | NUM_OUT | Divided clock value of each output |
| clk_out_en | output | NUM_OUT | Per-output drive flag (0 models high impedance) |

## Verification
Each period starts with a rising edge of the output on a source rising edge. That includes the first edge after reset, which is due one source edge after release. The high phase ends on a rising edge for even ratios and on a falling edge for odd ratios. Enable flags follow their inputs after one source cycle, and a select change applies from the next period boundary. The bench samples the outputs 5 ns after every source edge, which places it mid half-period. It counts high and total half-periods between output rising edges. A driver queues the expected ratio for each period as that period begins, and the monitor checks it when the period closes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Division ratio encoded by a select value.
  function automatic int unsigned ratio_of(input int unsigned sel, input int unsigned rmin);
    return rmin + sel;
  endfunction

  // Full source cycles the rising-edge phase stays high; for odd ratios the
  // falling-edge copy adds the extra half cycle.
  function automatic int unsigned high_cycles(input int unsigned n);
    return n / 2;
  endfunction

  function automatic logic is_odd(input int unsigned n);
    return (n % 2) == 1;
  endfunction

endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned RATIO_MIN = 3,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             phase_p,
  output logic             odd_q
);
  import clkdiv_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] new_last;
  logic [CNT_W-1:0] new_half;
  logic             new_odd;
  logic             wrap;
  int unsigned      n_new;

  always_comb begin
    n_new    = ratio_of(int'(sel), RATIO_MIN);
    new_last = CNT_W'(n_new - 1);
    new_half = CNT_W'(high_cycles(n_new));
    new_odd  = is_odd(n_new);
    cnt_inc  = cnt_q + 1'b1;
    wrap     = (cnt_q >= last_q);
  end

  // The counter rests at all ones in reset, so the first clean edge is a
  // period boundary: the ratio is latched and the output rises there.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      last_q  <= '0;
      half_q  <= '0;
      odd_q   <= 1'b0;
      phase_p <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      last_q  <= new_last;
      half_q  <= new_half;
      odd_q   <= new_odd;
      phase_p <= 1'b1;
    end else begin
      cnt_q   <= cnt_inc;
      phase_p <= (cnt_inc < half_q);
    end
  end

endmodule

// File: rtl/clkdiv_negstage.sv
module clkdiv_negstage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  // Half-cycle delayed copy of the rising-edge phase.
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_div,
  input  logic [NUM_OUT-1:0] oe_in,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_en
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clk_out[i] = clk_div;

    always_ff @(posedge clk) begin
      if (rst) clk_out_en[i] <= 1'b1;
      else     clk_out_en[i] <= oe_in[i];
    end
  end
endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned RATIO_MIN = 3,
  parameter int unsigned NUM_OUT   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_OUT-1:0] oe_in,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_en
);
  localparam int unsigned RATIO_MAX = RATIO_MIN + (2 ** SEL_W) - 1;
  localparam int unsigned CNT_W     = $clog2(RATIO_MAX);

  logic phase_p;
  logic phase_n;
  logic odd_q;
  logic clk_div;

  clkdiv_seq #(
    .SEL_W    (SEL_W),
    .RATIO_MIN(RATIO_MIN),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .phase_p(phase_p),
    .odd_q  (odd_q)
  );

  clkdiv_negstage u_neg (
    .clk(clk),
    .rst(rst),
    .d  (phase_p),
    .q  (phase_n)
  );

  // Both terms come straight from flops; the falling-edge term stretches the
  // high phase by half a cycle only for odd ratios.
  assign clk_div = phase_p | (odd_q & phase_n);

  clkdiv_fanout #(.NUM_OUT(NUM_OUT)) u_fan (
    .clk       (clk),
    .rst       (rst),
    .clk_div   (clk_div),
    .oe_in     (oe_in),
    .clk_out   (clk_out),
    .clk_out_en(clk_out_en)
  );

endmodule

// File: rtl/clkdiv_sel_chk.sv
module clkdiv_sel_chk #(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned MAX_RUN = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OUT-1:0] oe_in,
  input logic [NUM_OUT-1:0] clk_out,
  input logic [NUM_OUT-1:0] clk_out_en
);
  logic [7:0] run_q;
  logic       prev_q;

  // Length of the current run of equal rising-edge samples of output 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      if (clk_out[0] == prev_q) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
      else                      run_q <= 8'd1;
      prev_q <= clk_out[0];
    end
  end

  AST_OUTS_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (clk_out == {NUM_OUT{clk_out[0]}})); // R6

  AST_LOW_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (clk_out == '0)); // R3

  AST_RISE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (clk_out == '1)); // R4

  AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (clk_out_en == $past(oe_in))); // R7

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run_q <= 8'(MAX_RUN))); // R2

endmodule

bind clkdiv_sel clkdiv_sel_chk #(
  .NUM_OUT(NUM_OUT),
  .MAX_RUN((RATIO_MIN + (2 ** SEL_W)) / 2)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .oe_in     (oe_in),
  .clk_out   (clk_out),
  .clk_out_en(clk_out_en)
);

// File: tb/clkdiv_sel_bench.sv
`timescale 1ns/1ps
module clkdiv_sel_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] sel;
  logic [1:0] oe_in;
  logic [1:0] clk_out;
  logic [1:0] clk_out_en;

  clkdiv_sel u_clkdiv_sel (
    .clk(clk), .rst(rst), .sel(sel), .oe_in(oe_in),
    .clk_out(clk_out), .clk_out_en(clk_out_en)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    hi;
    int    per;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    fails  = 0;
  int    rise_cnt = 0;
  int    seen = 0;
  int    cur = 3;
  string cur_tag = "R1/R2";
  bit    mon_en = 1'b0;
  int    r6_err = 0;
  bit    prev_b = 1'b0;
  bit    started = 1'b0;
  int    hi_cnt = 0;
  int    per_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: one sample per source half-period, compare on each new period.
  task automatic sample_out();
    bit b;
    if (!mon_en) begin
      prev_b  = 1'b0;
      started = 1'b0;
      return;
    end
    b = clk_out[0];
    if (clk_out[1] != b) r6_err++;
    if (b && !prev_b) begin
      if (started) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1 scoreboard empty", per_cnt, 0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          chk(per_cnt == it.per, {it.tag, " R1 period"}, per_cnt, it.per);
          chk(hi_cnt == it.hi, {it.tag, " R2 high time"}, hi_cnt, it.hi);
        end
      end
      started = 1'b1;
      per_cnt = 1;
      hi_cnt  = 1;
      rise_cnt++;
    end else if (started) begin
      per_cnt++;
      if (b) hi_cnt++;
    end
    prev_b = b;
  endtask

  initial begin
    forever begin
      @(posedge clk); #5; sample_out();
      @(negedge clk); #5; sample_out();
    end
  end

  // Driver: queue the expected ratio of each period as it begins.
  task automatic next_period();
    exp_t it;
    wait (rise_cnt > seen);
    seen++;
    it.hi = cur; it.per = 2 * cur; it.tag = cur_tag;
    sb.push_back(it);
  endtask

  // The period just started keeps the old ratio (R5); sel changes one
  // source cycle into it, and the new ratio applies from the next period.
  task automatic seg(input logic [1:0] s, input int k);
    next_period();
    @(posedge clk); #5;
    sel = s;
    cur = 3 + int'(s);
    for (int i = 1; i < k; i++) next_period();
  endtask

  task automatic release_and_check();
    @(posedge clk); #5;
    seen = rise_cnt;
    rst  = 1'b0;
    #10; chk(clk_out == 2'b00, "R4 before first edge", clk_out, 0);
    #10; chk(clk_out == 2'b11, "R4 first edge high", clk_out, 3);
  endtask

  initial begin
    rst = 1'b1; sel = 2'b00; oe_in = 2'b00; mon_en = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk(clk_out == 2'b00, "R3 low in reset", clk_out, 0);
    chk(clk_out_en == 2'b11, "R7 enable reset value", clk_out_en, 3);
    oe_in = 2'b11;
    cur = 3;
    release_and_check();

    seg(2'b01, 3);
    seg(2'b10, 3);
    seg(2'b11, 3);
    seg(2'b00, 3);
    cur_tag = "R5";
    seg(2'b11, 2);
    seg(2'b10, 2);
    cur_tag = "R1/R2";

    @(posedge clk); #5;
    oe_in = 2'b00;
    @(posedge clk); #5;
    chk(clk_out_en == 2'b00, "R7 enable follows", clk_out_en, 0);
    cur_tag = "R8";
    seg(2'b01, 3);
    oe_in = 2'b10;
    @(posedge clk); #5;
    chk(clk_out_en == 2'b10, "R7 per-output enable", clk_out_en, 2);
    seg(2'b00, 3);
    oe_in = 2'b11;
    cur_tag = "R1/R2";
    seg(2'b10, 2);

    // Reset in the middle of an odd-ratio period.
    @(posedge clk); #5;
    mon_en = 1'b0;
    sb.delete();
    rst = 1'b1;
    sel = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk(clk_out == 2'b00, "R3 low while reset held", clk_out, 0);
    end
    mon_en = 1'b1;
    cur = 4;
    release_and_check();
    seg(2'b10, 3);
    seg(2'b00, 2);
    next_period();
    wait (rise_cnt > seen);
    #1;
    chk(r6_err == 0, "R6 outputs in phase", r6_err, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule